// File: doc/BRIEF.md
# Power-Good Window Supervisor

This block is the digital supervisor that sits behind the feedback-window comparators of a step-down converter. It receives two comparator flags, one that says the feedback voltage is above the lower acceptance limit and one that says it is below the upper limit. The feedback is inside the window when both flags are high. The block also receives an input-supply-present flag, the converter enable and a flag that says the soft-start ramp has reached its final level.

From these inputs it produces two outputs. The first is a pull-low request for the open-drain power-good pad, where 1 means drive the pin low. Power good is released only after the feedback has stayed inside the window for a long qualification delay. It is withdrawn after a short delay once the window is lost or the converter is disabled. Both delays are counted in system clock cycles. The second output selects the error-amplifier reference: the ramp reference first, then the fixed reference once the ramp has finished.

The comparator flags are asynchronous analog outputs, so they pass through a configurable synchronizer before use. The supply-present flag bypasses all delays, because without a valid supply the power-good logic has no meaning.

Top module: `pgood_supervisor`

## Requirements
- R1: While the synchronous active-low reset is low, `pg_pull_low` is 1 and `ref_fixed_sel` is 0. All delay counters are cleared.
- R2: The feedback is in-window only when `fb_over_lo` = 1 and `fb_under_hi` = 1. Both flags pass through `SYNC_STAGES` flip-flops before they are used.
- R3: A cycle is "good" when the synchronized window, `en` and `vin_ok` are all 1. With power good off, `pg_pull_low` goes to 0 after `PG_RISE_CYC` consecutive good clock edges.
- R4: Any non-good edge during the rise qualification restarts that count from zero. A run one edge short of `PG_RISE_CYC` leaves `pg_pull_low` at 1.
- R5: With power good on, `pg_pull_low` returns to 1 after `PG_FALL_CYC` consecutive edges where the window is lost or `en` is 0. A shorter bad run has no effect and resets the fall count.
- R6: `vin_ok` = 0 forces `pg_pull_low` to 1 in the same cycle, without waiting for a clock edge. It also clears the power-good state, so a fresh full rise delay is needed afterwards.
- R7: `ref_fixed_sel` is 0 (ramp reference) until the first edge where `ramp_done`, `en` and `vin_ok` are all 1. It becomes 1 after that edge and returns to 0 on any edge where `en` or `vin_ok` is 0.
- R8: Once `ref_fixed_sel` is 1, a later drop of `ramp_done` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Converter enable |
| vin_ok | input | 1 | Input supply above the minimum for valid logic |
| fb_over_lo | input | 1 | Comparator: feedback above the lower window limit (asynchronous) |
| fb_under_hi | input | 1 | Comparator: feedback below the upper window limit (asynchronous) |
| ramp_done | input | 1 | Soft-start ramp has reached its final level |
| pg_pull_low | output | 1 | Open-drain request: 1 drives the power-good pin low |
| ref_fixed_sel | output | 1 | Reference select: 0 ramp, 1 fixed |

## Verification
The bench builds the block with `PG_RISE_CYC` = 12, `PG_FALL_CYC` = 3 and `SYNC_STAGES` = 2. These values let one run cross the rise threshold, fall one edge short of it and trip the fall delay many times. The two-stage synchronizer keeps the comparator pipeline latency in play, so off-by-one timing errors between the window flags and the counters show up at the outputs. Long held stretches of random stimulus, together with directed runs of exactly threshold-minus-one, reach both boundaries of each delay.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

   typedef struct packed {
      logic over_lo;
      logic under_hi;
   } pgs_win_t;

   localparam int PGS_WIN_W = $bits(pgs_win_t);

   function automatic logic pgs_in_window(input pgs_win_t w);
      return w.over_lo & w.under_hi;
   endfunction

   function automatic int pgs_cnt_w(input int limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/pgs_flag_sync.sv
module pgs_flag_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("pgs_flag_sync: STAGES must be within 0..4");
   end
   if (W < 1) begin : g_bad_w
      $error("pgs_flag_sync: W must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/pgs_run_timer.sv
module pgs_run_timer
   import pgs_pkg::*;
#(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic hit
);

   localparam int            CW   = pgs_cnt_w(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("pgs_run_timer: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt;

   assign hit = run && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || hit) cnt <= '0;
      else                       cnt <= cnt + 1'b1;
   end

   // R4: the consecutive-edge count never passes its final value
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

   // R4: a broken run starts again from zero
   a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !hit || (LIMIT == 1));

endmodule

// File: rtl/pgs_ref_seq.sv
module pgs_ref_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic ramp_done,
   output logic fixed_sel
);

   always_ff @(posedge clk) begin
      if (!rst_n || !active) fixed_sel <= 1'b0;
      else if (ramp_done)    fixed_sel <= 1'b1;
   end

   // R8: while active, the fixed reference stays selected
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fixed_sel && active |=> fixed_sel);

   // R7: losing enable or supply returns to the ramp reference
   a_r7_back_to_ramp: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !fixed_sel);

   // R7: the switch to fixed needs a finished ramp
   a_r7_needs_ramp: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fixed_sel) |-> $past(ramp_done));

endmodule

// File: rtl/pgood_supervisor.sv
module pgood_supervisor
   import pgs_pkg::*;
#(
   parameter int PG_RISE_CYC = 100000,
   parameter int PG_FALL_CYC = 2500,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic vin_ok,
   input  logic fb_over_lo,
   input  logic fb_under_hi,
   input  logic ramp_done,
   output logic pg_pull_low,
   output logic ref_fixed_sel
);

   if (PG_FALL_CYC > PG_RISE_CYC) begin : g_bad_delays
      $error("pgood_supervisor: fall delay must not exceed rise delay");
   end

   pgs_win_t win_raw, win_s;
   logic     in_win, good, active;
   logic     pg_q;
   logic     rise_run, rise_hit, fall_run, fall_hit;

   assign win_raw.over_lo  = fb_over_lo;
   assign win_raw.under_hi = fb_under_hi;

   pgs_flag_sync #(.STAGES(SYNC_STAGES), .W(PGS_WIN_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (win_raw),
      .q     (win_s)
   );

   assign in_win = pgs_in_window(win_s);
   assign active = en & vin_ok;
   assign good   = in_win & en;

   assign rise_run = vin_ok & ~pg_q & good;
   assign fall_run = vin_ok &  pg_q & ~good;

   pgs_run_timer #(.LIMIT(PG_RISE_CYC)) u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (rise_run),
      .hit   (rise_hit)
   );

   pgs_run_timer #(.LIMIT(PG_FALL_CYC)) u_fall (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (fall_run),
      .hit   (fall_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || !vin_ok) pg_q <= 1'b0;
      else if (rise_hit)     pg_q <= 1'b1;
      else if (fall_hit)     pg_q <= 1'b0;
   end

   assign pg_pull_low = ~(pg_q & vin_ok);

   pgs_ref_seq u_ref (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .ramp_done (ramp_done),
      .fixed_sel (ref_fixed_sel)
   );

   // R3: power good is only granted after a good edge
   a_r3_rise_on_good: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_q) |-> $past(good && vin_ok));

   // R5: power good is only withdrawn on a bad edge or a lost supply
   a_r5_fall_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pg_q) |-> $past(!good || !vin_ok));

   // R6: a missing supply leaves the pin pulled low at the next edge
   a_r6_vin_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
      !vin_ok |=> pg_pull_low);

   // R5: a single good edge keeps an asserted power good
   a_r5_hold_on_good: assert property (@(posedge clk) disable iff (!rst_n)
      pg_q && good && vin_ok |=> pg_q);

endmodule

// File: tb/pgood_supervisor_tb_top.sv
`timescale 1ns/100ps
module pgood_supervisor_tb_top;

   localparam int RISE = 12;
   localparam int FALL = 3;
   localparam int SS   = 2;

   logic clk = 1'b0;
   logic rst_n, en, vin_ok, fb_over_lo, fb_under_hi, ramp_done;
   logic pg_pull_low, ref_fixed_sel;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   bit chk_on = 1'b0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   pgood_supervisor #(.PG_RISE_CYC(RISE), .PG_FALL_CYC(FALL), .SYNC_STAGES(SS)) dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .vin_ok(vin_ok),
      .fb_over_lo(fb_over_lo), .fb_under_hi(fb_under_hi), .ramp_done(ramp_done),
      .pg_pull_low(pg_pull_low), .ref_fixed_sel(ref_fixed_sel)
   );

   // reference model state, built from the requirements
   logic m_pipe [SS];
   logic m_pg, m_ref;
   int   m_good_run, m_bad_run;

   function automatic logic exp_pull(input logic pg, input logic vin);
      return !(pg && vin);
   endfunction

   always @(posedge clk) begin
      logic good;
      good = m_pipe[SS-1] && en;
      if (!rst_n) begin
         for (int i = 0; i < SS; i++) m_pipe[i] = 1'b0;
         m_pg = 1'b0; m_ref = 1'b0; m_good_run = 0; m_bad_run = 0;
      end else begin
         if (!vin_ok) begin
            m_pg = 1'b0; m_good_run = 0; m_bad_run = 0;
         end else if (!m_pg) begin
            m_bad_run = 0;
            m_good_run = good ? m_good_run + 1 : 0;
            if (m_good_run == RISE) begin m_pg = 1'b1; m_good_run = 0; end
         end else begin
            m_good_run = 0;
            m_bad_run = good ? 0 : m_bad_run + 1;
            if (m_bad_run == FALL) begin m_pg = 1'b0; m_bad_run = 0; end
         end
         if (!(en && vin_ok)) m_ref = 1'b0;
         else if (ramp_done)  m_ref = 1'b1;
         for (int i = SS-1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
         m_pipe[0] = fb_over_lo && fb_under_hi;
      end
   end

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         chk(pg_pull_low, exp_pull(m_pg, vin_ok), cur_req, "pg_pull_low");
         chk(ref_fixed_sel, m_ref, "R7", "ref_fixed_sel");
      end
   end

   task automatic drive(input logic e, input logic v, input logic lo, input logic hi,
                        input logic rd, input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk); #1;
         en = e; vin_ok = v; fb_over_lo = lo; fb_under_hi = hi; ramp_done = rd;
      end
   endtask

   initial begin
      logic e, v, lo, hi, rd;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; en = 1'b1; vin_ok = 1'b1; fb_over_lo = 1'b1; fb_under_hi = 1'b1;
      ramp_done = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(pg_pull_low, 1'b1, "R1", "reset pg_pull_low");
      chk(ref_fixed_sel, 1'b0, "R1", "reset ref_fixed_sel");
      #1; rst_n = 1'b1; ramp_done = 1'b0;
      chk_on = 1'b1;

      cur_req = "R7";  drive(1, 1, 0, 0, 0, 5);
      drive(1, 1, 0, 0, 1, 2);
      cur_req = "R8";  drive(1, 1, 0, 0, 0, 3);
      cur_req = "R3";  drive(1, 1, 1, 1, 0, RISE + SS + 4);
      cur_req = "R5";  drive(1, 1, 1, 0, 0, FALL - 1);
      drive(1, 1, 1, 1, 0, 6);
      drive(1, 1, 0, 1, 0, FALL + 4);
      cur_req = "R4";  drive(1, 1, 1, 1, 0, RISE - 1);
      drive(1, 1, 1, 0, 0, 1);
      drive(1, 1, 1, 1, 0, RISE + SS + 3);
      cur_req = "R6";  drive(1, 0, 1, 1, 0, 1);
      drive(1, 1, 1, 1, 0, RISE + SS + 3);
      cur_req = "R5";  drive(0, 1, 1, 1, 0, FALL + 3);
      cur_req = "R2";  drive(1, 1, 1, 1, 1, RISE + 2);
      drive(1, 1, 0, 1, 1, 2);

      e = 1; v = 1; lo = 1; hi = 1; rd = 0;
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(99) < 6)  lo = ~lo;
         if ($urandom_range(99) < 6)  hi = ~hi;
         if ($urandom_range(99) < 2)  e  = ~e;
         if ($urandom_range(99) < 1)  v  = ~v;
         if ($urandom_range(99) < 5)  rd = ~rd;
         if (!v && $urandom_range(99) < 30) v = 1'b1;
         cur_req = !v ? "R6" : "R2";
         drive(e, v, lo, hi, rd, 1);
      end
      drive(1, 1, 1, 1, 1, 4);
      chk_on = 1'b0;
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule